// File: doc/BRIEF.md
# Frame Trigger Selector and Interrupt Requester

This block turns one of two timing sources into a single-cycle frame trigger strobe for a multichannel DAC update controller. The internal source is the output of a timer divide chain, built elsewhere from two cascaded 16-bit counters that form a 32-bit divider. That output is synchronous to the block clock, and a trigger is its rising edge. The external source is an asynchronous, active-low pin. It passes through a two-flop synchronizer, and a trigger is its falling edge. A command word chooses the source. The command word can also suppress the trigger entirely.

Each trigger can post a bus interrupt request on one of seven priority levels. The request stays up until an acknowledge cycle at the same level is answered with the 8-bit vector held in the command word, or until software clears the interrupt enable. The acknowledge arrives on a valid/ready channel. The vector leaves on a second valid/ready channel. A response that the bus has not yet taken stays stable, and no further acknowledge is accepted while it waits. A trigger that arrives while a request is pending is absorbed and does not queue a second interrupt.

Top module: `trig_irq_top`

## Requirements
- R1: After reset, `trig_strobe` is 0, every `irq_lines` bit is 0, `rsp_valid` is 0 and `iack_ready` is 1.
- R2: With `cmd_word[5]`=0 and `cmd_word[6]`=1, a rising edge of `tmr_tick` yields `trig_strobe`=1 for exactly one cycle. This is the cycle after the first clock edge that samples `tmr_tick` high. Edges on `ext_trig_n` produce no strobe in this mode.
- R3: With `cmd_word[5]`=1 and `cmd_word[6]`=1, a falling edge of `ext_trig_n` yields `trig_strobe`=1 for exactly one cycle. This is the cycle after the third clock edge that samples the pin low, and the strobe is still 0 after the second. Edges on `tmr_tick` produce no strobe in this mode.
- R4: With `cmd_word[6]`=0, no edge on either source ever raises `trig_strobe`, and no interrupt request is posted.
- R5: When a strobe occurs with `cmd_word[3]`=1 and `irq_level` L in 1..7, bit L-1 of `irq_lines` rises in the cycle after the strobe. It is the only bit set. With L=0, no line is driven.
- R6: `irq_en_status` equals `cmd_word[3]`. While `cmd_word[3]`=0, a strobe posts no request, and clearing the bit drops a pending request one clock edge later.
- R7: When an acknowledge is accepted while a request is pending and `iack_level` equals `irq_level`, `rsp_valid` rises at the next edge with `rsp_vector` = `cmd_word[15:8]`. It stays valid and stable while `rsp_ready` is 0. The edge at which `rsp_valid` and `rsp_ready` are both 1 clears both `rsp_valid` and the request.
- R8: An acknowledge at a different level, or with no request pending, produces no response and leaves `irq_lines` unchanged.
- R9: A trigger that arrives while a request is pending does not queue. Once that request is answered, `irq_lines` stays 0 until a new trigger.
- R10: `vec_readback` equals `cmd_word[15:8]` in its low byte and zero in its upper byte.
- R11: `iack_ready` is 0 exactly while a vector response is waiting for `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_word | input | 16 | Command word: bit 3 interrupt enable, bit 5 source select, bit 6 trigger update mode, bits 15..8 vector |
| irq_level | input | 3 | Request level, 1..7 (0 = none) |
| tmr_tick | input | 1 | Internal timer output, synchronous, rising edge triggers |
| ext_trig_n | input | 1 | External trigger pin, asynchronous, active-low |
| trig_strobe | output | 1 | One-cycle frame update strobe |
| irq_en_status | output | 1 | Current interrupt enable |
| vec_readback | output | 16 | Vector readback, upper byte zero |
| irq_lines | output | 7 | Request lines, bit i = level i+1 |
| iack_valid | input | 1 | Acknowledge cycle present |
| iack_ready | output | 1 | Block can accept an acknowledge |
| iack_level | input | 3 | Level being acknowledged |
| rsp_valid | output | 1 | Vector response valid |
| rsp_ready | input | 1 | Bus takes the vector response |
| rsp_vector | output | 8 | Vector returned on acknowledge |

## Verification
The sweep covers every combination of source select, update mode, interrupt enable and request level. In each combination it fires the selected source, checks that the strobe lands on the exact cycle for that path, and fires the unselected source to confirm it is ignored. Both a wrong-level and a matching acknowledge are then tried against each posted request, with the response held under back-pressure before it is taken. Comparing these outcomes separates a source-select error from a gating error, a wrong-level error from an off-by-one line index, and a queuing fault from a correct release. A directed case then clears the enable while a request is pending.

// File: rtl/trig_irq_pkg.sv
package trig_irq_pkg;
  localparam int IE_BIT  = 3;
  localparam int SRC_BIT = 5;
  localparam int UPD_BIT = 6;
  localparam int VEC_LSB = 8;

  typedef enum logic {
    SRC_TIMER    = 1'b0,
    SRC_EXTERNAL = 1'b1
  } trig_src_e;

  typedef struct packed {
    logic      irq_en;
    trig_src_e src;
    logic      upd_mode;
  } ctl_bits_t;

  function automatic ctl_bits_t decode_ctl(input logic [15:0] w);
    ctl_bits_t c;
    c.irq_en   = w[IE_BIT];
    c.src      = trig_src_e'(w[SRC_BIT]);
    c.upd_mode = w[UPD_BIT];
    return c;
  endfunction
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q[i] <= IDLE_VAL;
        else if (i == 0) chain_q[i] <= d_async;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/trig_edge.sv
module trig_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);
  localparam logic IDLE = FALLING ? 1'b1 : 1'b0;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= IDLE;
    else        prev_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = prev_q & ~lvl;
    end else begin : g_rise
      assign evt = ~prev_q & lvl;
    end
  endgenerate

  // R2/R3: an edge event never repeats on consecutive cycles
  p_single_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/trig_irq_ctrl.sv
module trig_irq_ctrl #(
  parameter int LEVELS = 7,
  parameter int LVL_W  = 3,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_in,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] level,
  input  logic [VEC_W-1:0] vector,
  output logic [LEVELS-1:0] irq_lines,
  input  logic             iack_valid,
  output logic             iack_ready,
  input  logic [LVL_W-1:0] iack_level,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [VEC_W-1:0] rsp_vector
);
  logic             pending_q;
  logic             rsp_valid_q;
  logic [VEC_W-1:0] rsp_vec_q;
  logic             accept, hit, done;

  assign iack_ready = ~rsp_valid_q;
  assign accept     = iack_valid & iack_ready;
  assign hit        = accept & pending_q & (iack_level == level);
  assign done       = rsp_valid_q & rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_vec_q   <= '0;
    end else begin
      if (!irq_en || done)                pending_q <= 1'b0;
      else if (trig_in && level != '0)    pending_q <= 1'b1;
      if (done) rsp_valid_q <= 1'b0;
      else if (hit) begin
        rsp_valid_q <= 1'b1;
        rsp_vec_q   <= vector;
      end
    end
  end

  generate
    for (genvar i = 0; i < LEVELS; i++) begin : g_line
      assign irq_lines[i] = pending_q & (level == LVL_W'(i + 1));
    end
  endgenerate

  assign rsp_valid  = rsp_valid_q;
  assign rsp_vector = rsp_vec_q;

  p_onehot_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
  p_no_ie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (irq_lines == '0));
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_vector)));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (irq_lines == '0 && !rsp_valid));
  p_mismatch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && iack_level != level) |=> !rsp_valid);
endmodule

// File: rtl/trig_irq_top.sv
module trig_irq_top
  import trig_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVELS      = 7,
  parameter int CMD_W       = 16,
  parameter int VEC_W       = 8,
  parameter int LVL_W       = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              tmr_tick,
  input  logic              ext_trig_n,
  output logic              trig_strobe,
  output logic              irq_en_status,
  output logic [CMD_W-1:0]  vec_readback,
  output logic [LEVELS-1:0] irq_lines,
  input  logic              iack_valid,
  output logic              iack_ready,
  input  logic [LVL_W-1:0]  iack_level,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VEC_W-1:0]  rsp_vector
);
  ctl_bits_t        ctl;
  logic [VEC_W-1:0] vec;
  logic             ext_sync, ext_evt, tmr_evt, strobe_q;
  logic             unused_cmd_bits;

  assign ctl             = decode_ctl(16'(cmd_word));
  assign vec             = cmd_word[VEC_LSB +: VEC_W];
  assign unused_cmd_bits = ^cmd_word;

  trig_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) i_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ext_trig_n), .d_sync(ext_sync));

  trig_edge #(.FALLING(1'b1)) i_ext_edge (
    .clk(clk), .rst_n(rst_n), .lvl(ext_sync), .evt(ext_evt));

  trig_edge #(.FALLING(1'b0)) i_tmr_edge (
    .clk(clk), .rst_n(rst_n), .lvl(tmr_tick), .evt(tmr_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= ctl.upd_mode &
                            ((ctl.src == SRC_EXTERNAL) ? ext_evt : tmr_evt);
  end

  assign trig_strobe   = strobe_q;
  assign irq_en_status = ctl.irq_en;
  assign vec_readback  = {{(CMD_W-VEC_W){1'b0}}, vec};

  trig_irq_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W), .VEC_W(VEC_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_in(strobe_q), .irq_en(ctl.irq_en),
    .level(irq_level), .vector(vec), .irq_lines(irq_lines),
    .iack_valid(iack_valid), .iack_ready(iack_ready), .iack_level(iack_level),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_vector(rsp_vector));

  // R4: with update mode off, no strobe follows
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_word[UPD_BIT] |=> !trig_strobe);
  // R11: a waiting response blocks acknowledges
  p_backpressure_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> !iack_ready);
endmodule

// File: tb/test_trig_irq_top.sv
module test_trig_irq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [2:0]  irq_level = '0;
  logic        tmr_tick = 1'b0;
  logic        ext_trig_n = 1'b1;
  logic        trig_strobe, irq_en_status, iack_ready, rsp_valid;
  logic [15:0] vec_readback;
  logic [6:0]  irq_lines;
  logic        iack_valid = 1'b0;
  logic [2:0]  iack_level = '0;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_vector;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_irq_top i_trig_irq_top (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .irq_level(irq_level),
    .tmr_tick(tmr_tick), .ext_trig_n(ext_trig_n), .trig_strobe(trig_strobe),
    .irq_en_status(irq_en_status), .vec_readback(vec_readback),
    .irq_lines(irq_lines), .iack_valid(iack_valid), .iack_ready(iack_ready),
    .iack_level(iack_level), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_vector(rsp_vector));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive a trigger edge on a source and stop on the expected strobe cycle.
  task automatic fire(input int src);
    if (src == 0) begin
      tmr_tick = 1'b1;
      tick();
    end else begin
      ext_trig_n = 1'b0;
      tick();
      tick();
      check("R3", "strobe before sync latency", {31'b0, trig_strobe}, 0);
      tick();
    end
  endtask

  task automatic settle();
    tmr_tick = 1'b0;
    ext_trig_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) tick();
    // R1: reset state
    check("R1", "strobe", {31'b0, trig_strobe}, 0);
    check("R1", "irq_lines", {25'b0, irq_lines}, 0);
    check("R1", "rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1", "iack_ready", {31'b0, iack_ready}, 1);
    rst_n = 1'b1;
    tick();

    for (int src = 0; src < 2; src++)
      for (int mode = 0; mode < 2; mode++)
        for (int ie = 0; ie < 2; ie++)
          for (int lvl = 0; lvl < 8; lvl++) begin
            logic [7:0] vec;
            logic [6:0] exp_lines;
            bit posted;
            string rq;
            vec = 8'h5A ^ 8'(lvl * 37 + src * 3 + mode * 64 + ie * 16);
            cmd_word = {vec, 1'b0, 1'(mode), 1'(src), 1'b0, 1'(ie), 3'b101};
            irq_level = 3'(lvl);
            rq = (mode == 0) ? "R4" : ((src == 0) ? "R2" : "R3");
            posted = (mode == 1) && (ie == 1) && (lvl != 0);
            exp_lines = posted ? 7'(1 << (lvl - 1)) : 7'b0;
            tick();
            check("R10", "readback", {16'b0, vec_readback}, {24'b0, vec});
            check("R6", "ie status", {31'b0, irq_en_status}, ie);

            // Unselected source must not trigger
            if (src == 0) ext_trig_n = 1'b0; else tmr_tick = 1'b1;
            for (int k = 0; k < 4; k++) begin
              tick();
              check(rq, "unselected source", {31'b0, trig_strobe}, 0);
            end
            settle();

            fire(src);
            check(rq, "strobe", {31'b0, trig_strobe}, mode);
            tick();
            check(rq, "single cycle", {31'b0, trig_strobe}, 0);
            check((ie == 0) ? "R6" : "R5", "irq line", {25'b0, irq_lines},
                  {25'b0, exp_lines});
            settle();

            if (posted) begin
              fire(src);   // R9: second trigger while pending
              tick();
              check("R9", "lines while pending", {25'b0, irq_lines},
                    {25'b0, exp_lines});
              settle();
              iack_level = 3'((lvl % 7) + 1);
              iack_valid = 1'b1;
              tick();
              iack_valid = 1'b0;
              check("R8", "wrong level rsp", {31'b0, rsp_valid}, 0);
              check("R8", "wrong level lines", {25'b0, irq_lines},
                    {25'b0, exp_lines});
              iack_level = 3'(lvl);
              iack_valid = 1'b1;
              tick();
              iack_valid = 1'b0;
              check("R7", "rsp_valid", {31'b0, rsp_valid}, 1);
              check("R7", "vector", {24'b0, rsp_vector}, {24'b0, vec});
              check("R11", "iack_ready low", {31'b0, iack_ready}, 0);
              tick();
              check("R7", "held valid", {31'b0, rsp_valid}, 1);
              check("R7", "held vector", {24'b0, rsp_vector}, {24'b0, vec});
              check("R7", "line held", {25'b0, irq_lines}, {25'b0, exp_lines});
              rsp_ready = 1'b1;
              tick();
              rsp_ready = 1'b0;
              check("R7", "released rsp", {31'b0, rsp_valid}, 0);
              check("R7", "released line", {25'b0, irq_lines}, 0);
              check("R11", "iack_ready back", {31'b0, iack_ready}, 1);
              tick();
              check("R9", "no queued request", {25'b0, irq_lines}, 0);
            end else begin
              iack_level = 3'(lvl);
              iack_valid = 1'b1;
              tick();
              iack_valid = 1'b0;
              check("R8", "ack without request", {31'b0, rsp_valid}, 0);
              check("R8", "lines unchanged", {25'b0, irq_lines}, 0);
            end
            cmd_word = '0;
            settle();
          end

    // R6: clearing the enable drops a pending request
    cmd_word = {8'hC3, 8'b0110_1000};
    irq_level = 3'd4;
    tick();
    fire(1);
    tick();
    check("R5", "level 4 line", {25'b0, irq_lines}, 32'h8);
    cmd_word[3] = 1'b0;
    tick();
    check("R6", "enable cleared", {25'b0, irq_lines}, 0);
    check("R6", "status cleared", {31'b0, irq_en_status}, 0);
    cmd_word[3] = 1'b1;
    tick();
    check("R6", "no revival", {25'b0, irq_lines}, 0);
    settle();

    summary();
  end
endmodule